// File: doc/BRIEF.md
# Reorder-buffer operand source selector

At decode time each source register number is looked up associatively in a small reorder buffer. The block services several lookups per cycle. If any valid entry is allocated to that register, the youngest such entry in program order is the source. It supplies its result when the result has been written. When the result is still outstanding, it supplies its entry tag with a not-ready flag, so the reservation station can wait for that tag. If no entry matches, the operand comes from the architectural register file. Each lookup port drives one register-file read port, and the file's data returns in the same cycle.

The buffer is a circular queue. Allocation fills the tail, writeback fills an entry's result by tag, and retirement frees the head. Test inputs drive all three. The resolved operand is registered onto the operand bus one cycle after the lookup. The entry count must be a power of two.

Top module: `rob_operand_select`

## Requirements
- R1: While reset is held and in the cycle after it, op_valid, op_hit, op_ready, op_tag and op_data are all zero, and the buffer is empty.
- R2: A lookup of a register that no valid entry holds gives op_hit=0, op_ready=1 and op_data equal to rf_rdata of the same port, sampled in the lookup cycle.
- R3: A lookup that matches an entry whose result is written gives op_hit=1, op_ready=1, op_data equal to that result and op_tag equal to the entry index.
- R4: A lookup that matches an entry whose result is pending gives op_hit=1, op_ready=0, op_tag equal to the entry index and op_data=0.
- R5: When several valid entries hold the same register, the one allocated last is the source.
- R6: Each port's outputs appear one clock after its lookup. op_valid[p] equals lk_valid[p] delayed by one cycle.
- R7: A writeback to the selected entry in the same cycle as the lookup is forwarded: op_ready=1 and op_data=wb_data.
- R8: The tail entry index starts at 0 after reset and advances by one for each accepted allocation, wrapping at the entry count. An allocation while the buffer holds all of its entries is ignored.
- R9: Retirement frees the oldest entry. A retirement while the buffer is empty is ignored. A lookup in the same cycle as a retirement still sees the retiring entry.
- R10: All lookup ports work independently in the same cycle, each on its own register number and read port.
- R11: rf_raddr of port p equals lk_reg of port p in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Allocate a tail entry |
| alloc_reg | input | REG_W | Destination register of the new entry |
| wb_valid | input | 1 | Write a result into an entry |
| wb_tag | input | TAG_W | Entry written back |
| wb_data | input | DATA_W | Result value |
| retire_valid | input | 1 | Free the head entry |
| lk_valid | input | PORTS | Lookup request per port |
| lk_reg | input | PORTS*REG_W | Source register number per port |
| rf_raddr | output | PORTS*REG_W | Register-file read address per port |
| rf_rdata | input | PORTS*DATA_W | Register-file read data per port, combinational |
| op_valid | output | PORTS | Operand bus entry valid |
| op_hit | output | PORTS | Operand came from the buffer |
| op_ready | output | PORTS | Operand value is available |
| op_tag | output | PORTS*TAG_W | Entry index on a hit |
| op_data | output | PORTS*DATA_W | Operand value |

## Verification
A lookup can land in the same cycle as a writeback to the very entry it selects. It can also land in the same cycle as an allocation, or as a retirement, of an entry holding that register. Directed steps place a writeback on a pending entry while all ports look it up. The result must be the forwarded value, not the tag. A long pseudo-random sweep over four register numbers keeps the three update paths and lookups colliding. It judges every port against a bench model in which lookups see state from before the edge, with writebacks overlaid.

// File: rtl/rob_operand_select.sv
module rob_operand_select #(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 32,
  parameter int REG_W   = 8,
  parameter int PORTS   = 4,
  localparam int TAG_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_valid,
  input  logic [REG_W-1:0]        alloc_reg,
  input  logic                    wb_valid,
  input  logic [TAG_W-1:0]        wb_tag,
  input  logic [DATA_W-1:0]       wb_data,
  input  logic                    retire_valid,
  input  logic [PORTS-1:0]        lk_valid,
  input  logic [PORTS*REG_W-1:0]  lk_reg,
  output logic [PORTS*REG_W-1:0]  rf_raddr,
  input  logic [PORTS*DATA_W-1:0] rf_rdata,
  output logic [PORTS-1:0]        op_valid,
  output logic [PORTS-1:0]        op_hit,
  output logic [PORTS-1:0]        op_ready,
  output logic [PORTS*TAG_W-1:0]  op_tag,
  output logic [PORTS*DATA_W-1:0] op_data
);

  logic [ENTRIES-1:0] e_valid, e_ready;
  logic [REG_W-1:0]   e_reg  [ENTRIES];
  logic [DATA_W-1:0]  e_data [ENTRIES];
  logic [TAG_W-1:0]   head, tail;
  logic [CNT_W-1:0]   count;

  wire alloc_ok  = alloc_valid && (count != CNT_W'(ENTRIES));
  wire retire_ok = retire_valid && (count != '0);
  wire wb_ok     = wb_valid && e_valid[wb_tag];

  assign rf_raddr = lk_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid <= '0;
      e_ready <= '0;
      head    <= '0;
      tail    <= '0;
      count   <= '0;
    end else begin
      if (wb_ok) begin
        e_ready[wb_tag] <= 1'b1;
        e_data[wb_tag]  <= wb_data;
      end
      if (retire_ok) begin
        e_valid[head] <= 1'b0;
        head          <= head + 1'b1;
      end
      if (alloc_ok) begin
        e_valid[tail] <= 1'b1;
        e_ready[tail] <= 1'b0;
        e_reg[tail]   <= alloc_reg;
        e_data[tail]  <= '0;
        tail          <= tail + 1'b1;
      end
      count <= count + CNT_W'(alloc_ok) - CNT_W'(retire_ok);
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic             s_hit, s_fwd;
    logic [TAG_W-1:0] s_idx;
    wire [REG_W-1:0]  key = lk_reg[p*REG_W +: REG_W];

    always_comb begin
      s_hit = 1'b0;
      s_idx = '0;
      for (int k = 0; k < ENTRIES; k++) begin
        logic [TAG_W-1:0] e;
        e = head + TAG_W'(k);
        if (e_valid[e] && e_reg[e] == key) begin
          s_hit = 1'b1;
          s_idx = e;
        end
      end
    end

    assign s_fwd = s_hit && wb_ok && (wb_tag == s_idx);

    always_ff @(posedge clk) begin
      if (rst) begin
        op_valid[p]                  <= 1'b0;
        op_hit[p]                    <= 1'b0;
        op_ready[p]                  <= 1'b0;
        op_tag[p*TAG_W +: TAG_W]     <= '0;
        op_data[p*DATA_W +: DATA_W]  <= '0;
      end else begin
        op_valid[p]              <= lk_valid[p];
        op_hit[p]                <= lk_valid[p] && s_hit;
        op_ready[p]              <= lk_valid[p] && (!s_hit || s_fwd || e_ready[s_idx]);
        op_tag[p*TAG_W +: TAG_W] <= (lk_valid[p] && s_hit) ? s_idx : '0;
        if (!lk_valid[p])       op_data[p*DATA_W +: DATA_W] <= '0;
        else if (!s_hit)        op_data[p*DATA_W +: DATA_W] <= rf_rdata[p*DATA_W +: DATA_W];
        else if (s_fwd)         op_data[p*DATA_W +: DATA_W] <= wb_data;
        else if (e_ready[s_idx]) op_data[p*DATA_W +: DATA_W] <= e_data[s_idx];
        else                    op_data[p*DATA_W +: DATA_W] <= '0;
      end
    end
  end

endmodule

// File: rtl/rob_operand_select_chk.sv
module rob_operand_select_chk #(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 32,
  parameter int PORTS   = 4,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    alloc_valid,
  input logic                    retire_valid,
  input logic [PORTS-1:0]        lk_valid,
  input logic [PORTS-1:0]        op_valid,
  input logic [PORTS-1:0]        op_hit,
  input logic [PORTS-1:0]        op_ready,
  input logic [PORTS*DATA_W-1:0] op_data,
  input logic [CNT_W-1:0]        count
);

  assert_valid_delay_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> op_valid == $past(lk_valid));

  assert_full_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(ENTRIES) && alloc_valid && !retire_valid) |=> count == CNT_W'(ENTRIES));

  assert_empty_retire_R9: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && retire_valid && !alloc_valid) |=> count == '0);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(ENTRIES));

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    assert_pending_nodata_R4: assert property (@(posedge clk) disable iff (rst)
      (op_valid[p] && !op_ready[p]) |-> (op_hit[p] && op_data[p*DATA_W +: DATA_W] == '0));

    assert_miss_ready_R2: assert property (@(posedge clk) disable iff (rst)
      (op_valid[p] && !op_hit[p]) |-> op_ready[p]);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      !op_valid[p] |-> (!op_hit[p] && !op_ready[p]));
  end

endmodule

bind rob_operand_select rob_operand_select_chk #(
  .ENTRIES(ENTRIES), .DATA_W(DATA_W), .PORTS(PORTS)
) u_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .retire_valid(retire_valid),
  .lk_valid(lk_valid), .op_valid(op_valid), .op_hit(op_hit), .op_ready(op_ready),
  .op_data(op_data), .count(count)
);

// File: tb/tb_rob_operand_select.sv
module tb_rob_operand_select;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8, DW = 32, RW = 8, P = 4, TW = 3;

  logic clk = 0, rst = 1;
  logic alloc_valid = 0, wb_valid = 0, retire_valid = 0;
  logic [RW-1:0] alloc_reg = 0;
  logic [TW-1:0] wb_tag = 0;
  logic [DW-1:0] wb_data = 0;
  logic [P-1:0] lk_valid = 0;
  logic [P*RW-1:0] lk_reg = 0;
  logic [P*RW-1:0] rf_raddr;
  logic [P*DW-1:0] rf_rdata;
  logic [P-1:0] op_valid, op_hit, op_ready;
  logic [P*TW-1:0] op_tag;
  logic [P*DW-1:0] op_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] rfv(input logic [RW-1:0] r);
    return {16'hC0DE, r, ~r};
  endfunction

  for (genvar p = 0; p < P; p++) begin : g_rf
    assign rf_rdata[p*DW +: DW] = rfv(rf_raddr[p*RW +: RW]);
  end

  rob_operand_select dut (.*);

  int checks = 0, errors = 0;
  string force_tag = "";

  logic          m_valid [N];
  logic          m_ready [N];
  logic [RW-1:0] m_reg   [N];
  logic [DW-1:0] m_data  [N];
  int m_head = 0, m_tail = 0, m_count = 0;

  logic          x_valid [P];
  logic          x_hit   [P];
  logic          x_ready [P];
  logic [TW-1:0] x_tag   [P];
  logic [DW-1:0] x_data  [P];
  string         x_req   [P];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_ready[i] = 0; m_reg[i] = 0; m_data[i] = 0; end
    m_head = 0; m_tail = 0; m_count = 0;
  endtask

  task automatic expect_port(input int p);
    int nm; int idx; logic [RW-1:0] r;
    r = lk_reg[p*RW +: RW];
    nm = 0; idx = 0;
    for (int k = 0; k < N; k++) begin
      int e;
      e = (m_head + k) % N;
      if (m_valid[e] && m_reg[e] == r) begin nm++; idx = e; end
    end
    x_valid[p] = lk_valid[p];
    x_hit[p] = lk_valid[p] && nm > 0;
    x_tag[p] = x_hit[p] ? TW'(idx) : '0;
    if (!lk_valid[p]) begin
      x_ready[p] = 0; x_data[p] = 0; x_req[p] = "R6";
    end else if (nm == 0) begin
      x_ready[p] = 1; x_data[p] = rfv(r); x_req[p] = "R2";
    end else if (wb_valid && m_valid[wb_tag] && int'(wb_tag) == idx) begin
      x_ready[p] = 1; x_data[p] = wb_data; x_req[p] = "R7";
    end else if (m_ready[idx]) begin
      x_ready[p] = 1; x_data[p] = m_data[idx]; x_req[p] = (nm > 1) ? "R5" : "R3";
    end else begin
      x_ready[p] = 0; x_data[p] = 0; x_req[p] = (nm > 1) ? "R5" : "R4";
    end
    if (force_tag != "") x_req[p] = force_tag;
  endtask

  task automatic step();
    for (int p = 0; p < P; p++) begin
      expect_port(p);
      check(rf_raddr[p*RW +: RW] == lk_reg[p*RW +: RW], "R11",
            64'(rf_raddr[p*RW +: RW]), 64'(lk_reg[p*RW +: RW]));
    end
    @(posedge clk);
    if (wb_valid && m_valid[wb_tag]) begin m_ready[wb_tag] = 1; m_data[wb_tag] = wb_data; end
    begin
      bit a_ok, r_ok;
      a_ok = alloc_valid && m_count < N;
      r_ok = retire_valid && m_count > 0;
      if (r_ok) begin m_valid[m_head] = 0; m_head = (m_head + 1) % N; end
      if (a_ok) begin
        m_valid[m_tail] = 1; m_ready[m_tail] = 0; m_reg[m_tail] = alloc_reg; m_data[m_tail] = 0;
        m_tail = (m_tail + 1) % N;
      end
      m_count = m_count + int'(a_ok) - int'(r_ok);
    end
    @(negedge clk);
    for (int p = 0; p < P; p++) begin
      logic [DW+TW+2:0] act, exp;
      act = {op_valid[p], op_hit[p], op_ready[p], op_tag[p*TW +: TW], op_data[p*DW +: DW]};
      exp = {x_valid[p], x_hit[p], x_ready[p], x_tag[p], x_data[p]};
      check(act == exp, x_req[p], 64'(act), 64'(exp));
    end
  endtask

  task automatic idle();
    alloc_valid = 0; wb_valid = 0; retire_valid = 0; lk_valid = 0;
  endtask

  task automatic look_all(input logic [RW-1:0] r);
    lk_valid = '1;
    lk_reg = {P{r}};
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] lf;
    model_reset();
    lk_valid = '1; lk_reg = 32'h01020304;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held at zero during reset
    check({op_valid, op_hit, op_ready, op_tag, op_data} == '0, "R1", 64'(op_valid), 64'(0));
    rst = 0;
    idle();
    force_tag = "R1";
    step();
    look_all(8'h05); step();
    force_tag = "";

    // R10: distinct registers on all ports, buffer empty
    lk_valid = '1; lk_reg = {8'hF0, 8'h80, 8'h11, 8'h00}; step();
    // R4: pending entry
    idle(); alloc_valid = 1; alloc_reg = 8'h05; step();
    idle(); look_all(8'h05); step();
    // R3: written entry
    idle(); wb_valid = 1; wb_tag = 0; wb_data = 32'h1111_0000; step();
    idle(); look_all(8'h05); step();
    // R5: younger pending copy wins
    idle(); alloc_valid = 1; alloc_reg = 8'h05; step();
    idle(); look_all(8'h05); step();
    // R7: same-cycle writeback forwarded
    idle(); look_all(8'h05); wb_valid = 1; wb_tag = 1; wb_data = 32'h2222_0001; step();
    idle(); look_all(8'h05); step();
    // R10: mixed ports in one cycle
    idle(); lk_valid = 4'b1011; lk_reg = {8'h05, 8'h06, 8'h05, 8'h07}; step();
    // R8: fill to capacity, extra allocation ignored
    force_tag = "R8";
    for (int i = 0; i < 6; i++) begin idle(); alloc_valid = 1; alloc_reg = 8'h20 + 8'(i); step(); end
    idle(); alloc_valid = 1; alloc_reg = 8'h77; look_all(8'h25); step();
    idle(); look_all(8'h77); step();
    // R9: retire in same cycle as lookup still sees entry; then gone
    force_tag = "R9";
    idle(); retire_valid = 1; look_all(8'h05); step();
    idle(); retire_valid = 1; look_all(8'h05); step();
    idle(); look_all(8'h05); step();
    for (int i = 0; i < 7; i++) begin idle(); retire_valid = 1; step(); end
    idle(); look_all(8'h25); step();
    force_tag = "";

    // Sweep: colliding registers, mixed alloc/writeback/retire/lookups
    lf = 32'h1234_5678;
    for (int c = 0; c < 3000; c++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      idle();
      alloc_valid = lf[0] | lf[1];
      alloc_reg = 8'(lf[3:2]);
      retire_valid = lf[4] & lf[5];
      wb_valid = lf[6];
      wb_tag = lf[9:7];
      wb_data = lf ^ 32'hA5A5_0000;
      lk_valid = lf[13:10];
      lk_reg = {5'd0, lf[16:14], 5'd0, lf[19:17], 5'd0, lf[22:20], 5'd0, lf[25:23]};
      step();
    end

    idle(); step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule